// File: doc/BRIEF.md
# Interrupt Source Input Conditioner

This block sits in front of an interrupt controller and turns a vector of raw interrupt request lines into one pending bit per source. Each raw line is first brought into the local clock domain by a two-flop synchronizer. Each source then runs in one of two trigger classes. In level mode the pending bit tracks the synchronized input. In edge mode an active transition is captured in a latch and held there.

Sources are split by a build-time mask. External sources accept either polarity, so they can be high-level, low-level, rising-edge or falling-edge. Internal sources accept only the active-high variants, so their polarity input has no effect. A captured edge is released in any of three ways: the controller acknowledges that source by index, software writes a one to the clear strobe, or the source's trigger configuration changes. Software can also force an edge latch with a set strobe. The controller reads all pending bits as one word, and reads a per-source flag that tells edge mode from level mode.

Top module: `irq_src_cond`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, with every source in active-high level mode and every raw input low, `pending_o` reads all zeros.
- R2: For a source in level mode with active-high polarity (`trig_edge_i`=0, `trig_pol_i`=1), `pending_o` equals the raw input delayed by two clock edges. A pulse that has ended is no longer reported.
- R3: For an external source in level mode with `trig_pol_i`=0, `pending_o` is the inverse of the raw input delayed by two clock edges.
- R4: For a source in edge mode with `trig_pol_i`=1, a low-to-high raw transition sets its pending bit three clock edges after the input changes. The bit then stays set after the input returns low.
- R5: For an external source in edge mode with `trig_pol_i`=0, a high-to-low transition sets the pending bit, and a rising transition does not.
- R6: For an internal source (its `EXT_MASK` bit is 0), `trig_pol_i` is ignored: such a source always behaves as active-high level or rising edge.
- R7: A cycle with `ack_valid_i`=1 and `ack_id_i`=k clears the edge pending bit of source k on the next edge. Other sources are not affected.
- R8: A one on bit k of `sw_set_i` sets the pending bit of source k on the next edge if source k is in edge mode. The strobe has no effect in level mode.
- R9: A one on bit k of `sw_clr_i`, or an acknowledge of source k, clears source k's edge pending bit. This clear wins over a new edge or a set strobe arriving in the same cycle.
- R10: Any change of a source's effective trigger mode or polarity clears its latched edge on the next clock edge.
- R11: `edge_mode_o[k]` is 1 exactly when source k is configured for edge mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_raw_i | input | N_SRC | Raw, asynchronous interrupt request lines |
| trig_edge_i | input | N_SRC | 1 = edge mode, 0 = level mode, per source |
| trig_pol_i | input | N_SRC | 1 = high/rising, 0 = low/falling (external sources only) |
| ack_valid_i | input | 1 | Controller acknowledge strobe |
| ack_id_i | input | ID_W | Index of the source being acknowledged |
| sw_set_i | input | N_SRC | Write-one-to-set strobes for edge pending bits |
| sw_clr_i | input | N_SRC | Write-one-to-clear strobes for edge pending bits |
| pending_o | output | N_SRC | Pending bit of every source |
| edge_mode_o | output | N_SRC | Per-source edge/level flag |

## Verification
Directed patterns exercise each trigger class on its own. A held level is compared with a short pulse, which shows whether a level source follows its input or latches it. A rising transition is compared with a falling one under both polarities, which shows whether polarity is applied to the right sources and is ignored on internal sources. Strobes are placed on the same cycle as a new edge to show clear-over-set priority, and acknowledges are sent for a non-matching index to show they hit only their own source. Long random runs then toggle inputs every cycle, with occasional mode flips and strobes. Against a cycle model in the bench, these runs separate the latch, synchronizer-delay and mode-change clearing behaviour.

// File: rtl/isc_pkg.sv
package isc_pkg;

  typedef struct packed {
    logic is_edge;
    logic act_high;
  } trig_cfg_t;

  function automatic logic active_lvl(input logic v, input logic hi);
    return hi ? v : ~v;
  endfunction

endpackage

// File: rtl/isc_sync.sv
module isc_sync #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;
endmodule

// File: rtl/isc_ack_dec.sv
module isc_ack_dec #(
  parameter int unsigned N_SRC = 8,
  parameter int unsigned ID_W  = $clog2(N_SRC)
) (
  input  logic             valid_i,
  input  logic [ID_W-1:0]  id_i,
  output logic [N_SRC-1:0] hit_o
);
  for (genvar g = 0; g < N_SRC; g++) begin : g_hit
    assign hit_o[g] = valid_i && (id_i == ID_W'(g));
  end
endmodule

// File: rtl/isc_src.sv
module isc_src
  import isc_pkg::*;
#(
  parameter bit IS_EXT = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic edge_sel_i,
  input  logic pol_i,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  trig_cfg_t cfg_d, cfg_q;
  logic prev_q, lat_q, lat_d;
  logic act, act_prev, evt, mode_chg;

  // internal sources are forced active-high
  assign cfg_d.is_edge  = edge_sel_i;
  assign cfg_d.act_high = IS_EXT ? pol_i : 1'b1;

  assign act      = active_lvl(lvl_i, cfg_d.act_high);
  assign act_prev = active_lvl(prev_q, cfg_d.act_high);
  assign evt      = cfg_d.is_edge & act & ~act_prev;
  assign mode_chg = (cfg_d != cfg_q);

  always_comb begin
    if (mode_chg || !cfg_d.is_edge || clr_i) lat_d = 1'b0;
    else                                      lat_d = lat_q | evt | set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      lat_q  <= 1'b0;
      cfg_q  <= '{is_edge: 1'b0, act_high: 1'b1};
    end else begin
      prev_q <= lvl_i;
      lat_q  <= lat_d;
      cfg_q  <= cfg_d;
    end
  end

  assign pend_o = cfg_d.is_edge ? lat_q : act;

  assert_clr_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !lat_q);
  assert_mode_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_chg |=> !lat_q);
  assert_edge_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lat_q && !clr_i && !mode_chg) |=> lat_q);
  assert_sw_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && cfg_d.is_edge && !clr_i && !mode_chg) |=> lat_q);
endmodule

// File: rtl/irq_src_cond.sv
module irq_src_cond #(
  parameter int unsigned      N_SRC    = 8,
  parameter int unsigned      ID_W     = $clog2(N_SRC),
  parameter logic [N_SRC-1:0] EXT_MASK = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] irq_raw_i,
  input  logic [N_SRC-1:0] trig_edge_i,
  input  logic [N_SRC-1:0] trig_pol_i,
  input  logic             ack_valid_i,
  input  logic [ID_W-1:0]  ack_id_i,
  input  logic [N_SRC-1:0] sw_set_i,
  input  logic [N_SRC-1:0] sw_clr_i,
  output logic [N_SRC-1:0] pending_o,
  output logic [N_SRC-1:0] edge_mode_o
);
  logic [N_SRC-1:0] sync_lvl, ack_hit;

  isc_sync #(.WIDTH(N_SRC)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(irq_raw_i),
    .sync_o (sync_lvl)
  );

  isc_ack_dec #(.N_SRC(N_SRC), .ID_W(ID_W)) u_ack (
    .valid_i(ack_valid_i),
    .id_i   (ack_id_i),
    .hit_o  (ack_hit)
  );

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    isc_src #(.IS_EXT(EXT_MASK[g])) u_src (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .lvl_i     (sync_lvl[g]),
      .edge_sel_i(trig_edge_i[g]),
      .pol_i     (trig_pol_i[g]),
      .set_i     (sw_set_i[g]),
      .clr_i     (sw_clr_i[g] | ack_hit[g]),
      .pend_o    (pending_o[g])
    );
  end

  assign edge_mode_o = trig_edge_i;

  assert_ack_onehot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ack_hit));
  assert_ack_only_valid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_valid_i |-> (ack_hit == '0));
endmodule

// File: tb/sim_irq_src_cond.sv
module sim_irq_src_cond;
  localparam int N = 8;
  localparam logic [N-1:0] EXT = 8'h0F;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] raw = '0, edge_r = '0, pol_r = '1, sw_set = '0, sw_clr = '0;
  logic ack_v = 1'b0;
  logic [2:0] ack_id = '0;
  logic [N-1:0] pending, edge_mode;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_src_cond #(.N_SRC(N), .ID_W(3), .EXT_MASK(EXT)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .irq_raw_i(raw), .trig_edge_i(edge_r),
    .trig_pol_i(pol_r), .ack_valid_i(ack_v), .ack_id_i(ack_id),
    .sw_set_i(sw_set), .sw_clr_i(sw_clr), .pending_o(pending), .edge_mode_o(edge_mode)
  );

  // cycle model built from the requirements
  logic [N-1:0] m_s1, m_s2, m_prev, m_lat, m_lat_n;
  logic [1:0]   m_cfg [N];

  function automatic logic eff_pol(int i);
    return EXT[i] ? pol_r[i] : 1'b1;
  endfunction

  function automatic logic exp_pend(int i);
    logic a;
    a = eff_pol(i) ? m_s2[i] : ~m_s2[i];
    return edge_r[i] ? m_lat[i] : a;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_prev = '0; m_lat = '0;
      for (int i = 0; i < N; i++) m_cfg[i] = 2'b01;
    end else begin
      for (int i = 0; i < N; i++) begin
        logic p, a, ap, evt, chg, clr;
        p   = eff_pol(i);
        a   = p ? m_s2[i] : ~m_s2[i];
        ap  = p ? m_prev[i] : ~m_prev[i];
        evt = edge_r[i] & a & ~ap;
        chg = ({edge_r[i], p} != m_cfg[i]);
        clr = sw_clr[i] | (ack_v && ack_id == 3'(i));
        m_lat_n[i] = (chg || !edge_r[i] || clr) ? 1'b0 : (m_lat[i] | evt | sw_set[i]);
        m_cfg[i] = {edge_r[i], p};
      end
      m_lat = m_lat_n; m_prev = m_s2; m_s2 = m_s1; m_s1 = raw;
    end
  end

  task automatic chk_bit(int i, logic exp, string req);
    n_chk++;
    if (pending[i] !== exp) begin
      n_fail++;
      $display("FAIL %s src%0d pending actual=%b expected=%b", req, i, pending[i], exp);
    end
  endtask

  task automatic chk_all(string req);
    logic [N-1:0] e;
    for (int i = 0; i < N; i++) e[i] = exp_pend(i);
    n_chk++;
    if (pending !== e) begin
      n_fail++;
      $display("FAIL %s pending actual=%h expected=%h", req, pending, e);
    end
  endtask

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'h5EED);
    cyc(3);
    rst_n = 1'b1;
    cyc();
    n_chk++;
    if (pending !== '0) begin n_fail++; $display("FAIL R1 pending actual=%h expected=00", pending); end

    // R2 level follows input, two-edge delay
    raw[0] = 1'b1; cyc(); chk_bit(0, 1'b0, "R2");
    cyc(); chk_bit(0, 1'b1, "R2");
    raw[0] = 1'b0; cyc(2); chk_bit(0, 1'b0, "R2");

    // R3 external low level
    pol_r[1] = 1'b0; #1 chk_bit(1, 1'b1, "R3");
    raw[1] = 1'b1; cyc(2); chk_bit(1, 1'b0, "R3");

    // R4 rising edge latch
    edge_r[2] = 1'b1; cyc(2); chk_bit(2, 1'b0, "R4");
    raw[2] = 1'b1; cyc(2); chk_bit(2, 1'b0, "R4");
    cyc(); chk_bit(2, 1'b1, "R4");
    raw[2] = 1'b0; cyc(3); chk_bit(2, 1'b1, "R4");

    // R7 acknowledge by index
    ack_v = 1'b1; ack_id = 3'd5; cyc(); ack_v = 1'b0;
    cyc(); chk_bit(2, 1'b1, "R7");
    ack_v = 1'b1; ack_id = 3'd2; cyc(); ack_v = 1'b0;
    chk_bit(2, 1'b0, "R7");

    // R5 falling edge on external source
    edge_r[3] = 1'b1; pol_r[3] = 1'b0; raw[3] = 1'b1; cyc(4);
    chk_bit(3, 1'b0, "R5");
    raw[3] = 1'b0; cyc(3); chk_bit(3, 1'b1, "R5");

    // R6 polarity ignored on internal sources
    edge_r[4] = 1'b1; pol_r[4] = 1'b0; cyc(2);
    raw[4] = 1'b1; cyc(3); chk_bit(4, 1'b1, "R6");
    pol_r[5] = 1'b0; #1 chk_bit(5, 1'b0, "R6");

    // R8 software set, edge only
    edge_r[6] = 1'b1; cyc(2);
    sw_set[6] = 1'b1; sw_set[7] = 1'b1; cyc(); sw_set = '0;
    chk_bit(6, 1'b1, "R8"); chk_bit(7, 1'b0, "R8");

    // R9 clear wins over set and over a new edge
    sw_clr[6] = 1'b1; sw_set[6] = 1'b1; cyc(); sw_clr = '0; sw_set = '0;
    chk_bit(6, 1'b0, "R9");
    raw[2] = 1'b1; cyc(2);
    sw_clr[2] = 1'b1; cyc(); sw_clr = '0;
    chk_bit(2, 1'b0, "R9");
    cyc(); chk_bit(2, 1'b0, "R9");

    // R10 config change drops latched edge
    pol_r[3] = 1'b1; cyc(); chk_bit(3, 1'b0, "R10");

    // R11 edge/level flag
    n_chk++;
    if (edge_mode !== edge_r) begin
      n_fail++; $display("FAIL R11 edge_mode actual=%h expected=%h", edge_mode, edge_r);
    end

    // random phase against the model
    for (int k = 0; k < 4000; k++) begin
      cyc();
      chk_all("R4/R2 random");
      raw = N'($urandom);
      if ($urandom % 24 == 0) edge_r = N'($urandom);
      if ($urandom % 24 == 0) pol_r  = N'($urandom);
      sw_set = ($urandom % 4 == 0) ? N'($urandom) : '0;
      sw_clr = ($urandom % 5 == 0) ? N'($urandom) : '0;
      ack_v  = ($urandom % 3 == 0);
      ack_id = 3'($urandom);
    end
    cyc(); chk_all("R10 random");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule